// File: doc/BRIEF.md
# DMA Channel Transfer Counter with Circular Reload

This block keeps the count of transfers still owed by one DMA channel and decides when the channel stops. Software sets a programmed count. It can also ask for circular operation and say whether the DMA engine or the peripheral paces the data flow. The channel starts on a rising edge of its enable. From then on, each completed single transfer, reported by a one-cycle done strobe, lowers the count by one.

The channel can end a run in two ways. In normal mode it goes inactive when the count reaches zero and raises a sticky finish flag. In circular mode the count is refilled from the value captured at start, the finish flag is raised on every wrap, and the channel keeps serving requests. It does so until its enable is removed or a transfer error arrives. Circular operation is only meaningful while the DMA engine paces the flow. When the peripheral paces the flow, the circular request is dropped at the moment the channel starts.

A transfer error stops the channel at once and leaves a sticky error flag. Both flags are cleared by a one-cycle clear pulse.

Top module: `xfer_cnt_top`

## Requirements
- R1: After reset, `curCount` is 0 and `chanActive`, `circActive`, `finishFlag` and `errFlag` are all 0.
- R2: A rising edge of `chanEn` while the channel is inactive and `progCount` is nonzero makes `chanActive` 1 and `curCount` equal to `progCount` on the next clock edge.
- R3: While active, with `chanEn` 1 and no error, each cycle with `beatDone` 1 and `curCount` above 1 lowers `curCount` by exactly one.
- R4: In normal mode, the `beatDone` that meets `curCount` = 1 sets `curCount` to 0, clears `chanActive` and sets `finishFlag`, all on the same edge.
- R5: `finishFlag` stays set until `finishClr` is pulsed. If a finish event and `finishClr` fall in the same cycle, the flag is set.
- R6: With `circEn` 1 and `periphFlow` 0 at start, `circActive` is 1. The `beatDone` that meets `curCount` = 1 then reloads the count, sets `finishFlag` and keeps `chanActive` at 1, on every wrap.
- R7: If `periphFlow` is 1 at start, `circActive` is 0 whatever `circEn` is, and the run ends as in R4.
- R8: Clearing `chanEn` while the channel is active clears `chanActive` on the next edge, and `curCount` holds its value.
- R9: `xferErr` while the channel is active clears `chanActive` and sets `errFlag` on the next edge, and `curCount` holds its value. `errFlag` stays set until `errClr` is pulsed.
- R10: The reload value is the `progCount` captured at start. Changes to `progCount` during a run have no effect on it.
- R11: A rising edge of `chanEn` with `progCount` = 0 does not start the channel.
- R12: While the channel is inactive, `beatDone` and `xferErr` leave `curCount`, `chanActive` and `errFlag` unchanged.
- R13: Starting requires a new rising edge of `chanEn`. An enable held high after a stop or after a refused start does not restart the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel enable level; a rising edge starts a run |
| progCount | input | CNT_W | Programmed transfer count |
| circEn | input | 1 | Circular operation request |
| periphFlow | input | 1 | 1 = peripheral paces the flow, 0 = DMA paces it |
| beatDone | input | 1 | One completed transfer this cycle |
| xferErr | input | 1 | Transfer error this cycle |
| finishClr | input | 1 | Clear pulse for `finishFlag` |
| errClr | input | 1 | Clear pulse for `errFlag` |
| curCount | output | CNT_W | Remaining transfer count |
| chanActive | output | 1 | Channel is running |
| circActive | output | 1 | Circular operation in force for this run |
| finishFlag | output | 1 | Sticky full-transfer-finish flag |
| errFlag | output | 1 | Sticky transfer-error flag |

## Verification
The assertions assume that every input is a defined 0 or 1 after reset. They also assume that the clear pulses and strobes are sampled as plain levels on each edge. The stop and wrap properties do not assume any ordering among the events: each one names the priority it depends on (error first, then loss of enable, then a completed transfer) in its own antecedent. The bench changes inputs only on the falling clock edge and applies one event per cycle, except in the cases that deliberately overlap events to test that priority.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;

  // Strobes issued by the control FSM to the count datapath, one cycle each.
  typedef struct packed {
    logic load;       // capture programmed count and reload value
    logic dec;        // count minus one
    logic reload;     // count back to captured reload value
    logic setFinish;  // raise sticky finish flag
    logic setErr;     // raise sticky error flag
  } cntStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } chanState_t;

endpackage

// File: rtl/xfer_cnt_ctrl.sv
module xfer_cnt_ctrl
  import xfer_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic       circEn,
  input  logic       periphFlow,
  input  logic       beatDone,
  input  logic       xferErr,
  input  logic       countIsOne,
  input  logic       progIsZero,
  output cntStrobe_t strb,
  output logic       chanActive,
  output logic       circActive
);

  chanState_t stateQ, stateD;
  logic       enPrevQ;
  logic       circQ, circD;
  logic       enRise;
  logic       lastBeat;

  assign enRise   = chanEn && !enPrevQ;
  assign lastBeat = beatDone && countIsOne;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    circD  = circQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (enRise && !progIsZero) begin
          strb.load = 1'b1;
          stateD    = ST_RUN;
          // peripheral-paced flow overrides any circular request at start
          circD     = circEn && !periphFlow;
        end
      end
      ST_RUN: begin
        if (xferErr) begin
          strb.setErr = 1'b1;
          stateD      = ST_IDLE;
        end else if (!chanEn) begin
          stateD = ST_IDLE;
        end else if (lastBeat) begin
          strb.setFinish = 1'b1;
          if (circQ) begin
            strb.reload = 1'b1;
          end else begin
            strb.dec = 1'b1;
            stateD   = ST_IDLE;
          end
        end else if (beatDone) begin
          strb.dec = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      enPrevQ <= 1'b0;
      circQ   <= 1'b0;
    end else begin
      stateQ  <= stateD;
      enPrevQ <= chanEn;
      circQ   <= circD;
    end
  end

  assign chanActive = (stateQ == ST_RUN);
  assign circActive = circQ;

endmodule

// File: rtl/xfer_cnt_dp.sv
module xfer_cnt_dp
  import xfer_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] progCount,
  input  cntStrobe_t       strb,
  input  logic             finishClr,
  input  logic             errClr,
  output logic [CNT_W-1:0] curCount,
  output logic             countIsOne,
  output logic             progIsZero,
  output logic             finishFlag,
  output logic             errFlag
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;
  logic             finishQ;
  logic             errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= ZERO;
      reloadQ <= ZERO;
    end else if (strb.load) begin
      countQ  <= progCount;
      reloadQ <= progCount;
    end else if (strb.reload) begin
      countQ <= reloadQ;
    end else if (strb.dec) begin
      countQ <= countQ - ONE;
    end
  end

  // set has priority over the clear pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      finishQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (strb.setFinish)  finishQ <= 1'b1;
      else if (finishClr)  finishQ <= 1'b0;
      if (strb.setErr)     errQ    <= 1'b1;
      else if (errClr)     errQ    <= 1'b0;
    end
  end

  assign curCount   = countQ;
  assign countIsOne = (countQ == ONE);
  assign progIsZero = (progCount == ZERO);
  assign finishFlag = finishQ;
  assign errFlag    = errQ;

endmodule

// File: rtl/xfer_cnt_top.sv
module xfer_cnt_top
  import xfer_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic [CNT_W-1:0] progCount,
  input  logic             circEn,
  input  logic             periphFlow,
  input  logic             beatDone,
  input  logic             xferErr,
  input  logic             finishClr,
  input  logic             errClr,
  output logic [CNT_W-1:0] curCount,
  output logic             chanActive,
  output logic             circActive,
  output logic             finishFlag,
  output logic             errFlag
);

  cntStrobe_t strb;
  logic       countIsOne;
  logic       progIsZero;

  xfer_cnt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chanEn     (chanEn),
    .circEn     (circEn),
    .periphFlow (periphFlow),
    .beatDone   (beatDone),
    .xferErr    (xferErr),
    .countIsOne (countIsOne),
    .progIsZero (progIsZero),
    .strb       (strb),
    .chanActive (chanActive),
    .circActive (circActive)
  );

  xfer_cnt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .progCount  (progCount),
    .strb       (strb),
    .finishClr  (finishClr),
    .errClr     (errClr),
    .curCount   (curCount),
    .countIsOne (countIsOne),
    .progIsZero (progIsZero),
    .finishFlag (finishFlag),
    .errFlag    (errFlag)
  );

endmodule

// File: rtl/xfer_cnt_chk.sv
module xfer_cnt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic [CNT_W-1:0] progCount,
  input logic             beatDone,
  input logic             xferErr,
  input logic             finishClr,
  input logic             periphFlow,
  input logic [CNT_W-1:0] curCount,
  input logic             chanActive,
  input logic             circActive,
  input logic             finishFlag,
  input logic             errFlag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic runBeat;
  assign runBeat = chanActive && chanEn && !xferErr && beatDone;

  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanActive) |-> curCount == $past(progCount));

  a_r3_dec: assert property (@(posedge clk) disable iff (!rstN)
    runBeat && curCount > ONE |=> curCount == $past(curCount) - ONE);

  a_r4_finish: assert property (@(posedge clk) disable iff (!rstN)
    runBeat && !circActive && curCount == ONE |=> !chanActive && finishFlag && curCount == '0);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    finishFlag && !finishClr |=> finishFlag);

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
    runBeat && circActive && curCount == ONE |=> chanActive && finishFlag && curCount != '0);

  a_r7_periph: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanActive) && $past(periphFlow) |-> !circActive);

  a_r8_disable: assert property (@(posedge clk) disable iff (!rstN)
    chanActive && !chanEn && !xferErr |=> !chanActive && $stable(curCount));

  a_r9_err: assert property (@(posedge clk) disable iff (!rstN)
    chanActive && xferErr |=> !chanActive && errFlag && $stable(curCount));

  a_r12_idle: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive |=> chanActive || $stable(curCount));

  a_r12_noerr: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive && !errFlag |=> !errFlag);

endmodule

bind xfer_cnt_top xfer_cnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chanEn     (chanEn),
  .progCount  (progCount),
  .beatDone   (beatDone),
  .xferErr    (xferErr),
  .finishClr  (finishClr),
  .periphFlow (periphFlow),
  .curCount   (curCount),
  .chanActive (chanActive),
  .circActive (circActive),
  .finishFlag (finishFlag),
  .errFlag    (errFlag)
);

// File: tb/xfer_cnt_top_bench.sv
`timescale 1ns/1ps
module xfer_cnt_top_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic         chanEn, circEn, periphFlow, beatDone, xferErr, finishClr, errClr;
  logic [W-1:0] progCount;
  logic [W-1:0] curCount;
  logic         chanActive, circActive, finishFlag, errFlag;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  xfer_cnt_top #(.CNT_W(W)) u_xfer_cnt_top (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .progCount(progCount),
    .circEn(circEn), .periphFlow(periphFlow), .beatDone(beatDone),
    .xferErr(xferErr), .finishClr(finishClr), .errClr(errClr),
    .curCount(curCount), .chanActive(chanActive), .circActive(circActive),
    .finishFlag(finishFlag), .errFlag(errFlag)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearFinish();
    finishClr = 1'b1; step(); finishClr = 1'b0;
    check("R5 finish cleared by pulse", int'(finishFlag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; chanEn = 0; circEn = 0; periphFlow = 0; beatDone = 0;
    xferErr = 0; finishClr = 0; errClr = 0; progCount = '0;
    repeat (3) step();
    rstN = 1'b1; step();
    check("R1 reset count", int'(curCount), 0);
    check("R1 reset active", int'(chanActive), 0);
    check("R1 reset circ", int'(circActive), 0);
    check("R1 reset finish", int'(finishFlag), 0);
    check("R1 reset err", int'(errFlag), 0);

    // normal mode sweep
    for (int n = 1; n < (1 << W); n++) begin
      progCount = W'(n); chanEn = 1; step();
      check("R2 start active", int'(chanActive), 1);
      check("R2 start count", int'(curCount), n);
      beatDone = 1;
      for (int k = 1; k < n; k++) begin
        step();
        check("R3 decrement", int'(curCount), n - k);
        check("R3 still active", int'(chanActive), 1);
      end
      step();
      check("R4 end count", int'(curCount), 0);
      check("R4 end inactive", int'(chanActive), 0);
      check("R4 finish set", int'(finishFlag), 1);
      beatDone = 0; step();
      check("R5 finish sticky", int'(finishFlag), 1);
      chanEn = 0; step();
      clearFinish();
    end

    // circular mode sweep, two wraps each
    circEn = 1;
    for (int n = 1; n <= 6; n++) begin
      progCount = W'(n); chanEn = 1; step();
      check("R6 circ in force", int'(circActive), 1);
      beatDone = 1;
      for (int r = 0; r < 2; r++) begin
        for (int k = 1; k < n; k++) begin
          step();
          check("R6 circ decrement", int'(curCount), n - k);
        end
        step();
        check("R6 wrap count", int'(curCount), n);
        check("R6 wrap active", int'(chanActive), 1);
        check("R6 wrap finish", int'(finishFlag), 1);
        beatDone = 0; clearFinish(); beatDone = 1;
      end
      beatDone = 0; chanEn = 0; step();
      check("R8 disable inactive", int'(chanActive), 0);
      check("R8 disable holds count", int'(curCount), n);
    end

    // R8 mid-count in circular mode
    progCount = 4'd5; chanEn = 1; step();
    beatDone = 1; step(); step(); beatDone = 0;
    chanEn = 0; step();
    check("R8 mid-run stop", int'(chanActive), 0);
    check("R8 mid-run count", int'(curCount), 3);

    // R10 reload uses captured value
    progCount = 4'd3; chanEn = 1; step();
    progCount = 4'd9; beatDone = 1;
    repeat (3) step();
    check("R10 reload captured", int'(curCount), 3);
    beatDone = 0; chanEn = 0; step(); clearFinish();

    // R7 peripheral-paced flow overrides circular request
    periphFlow = 1; progCount = 4'd3; chanEn = 1; step();
    check("R7 circ forced off", int'(circActive), 0);
    beatDone = 1; repeat (3) step(); beatDone = 0;
    check("R7 run ends", int'(chanActive), 0);
    check("R7 count zero", int'(curCount), 0);
    chanEn = 0; periphFlow = 0; circEn = 0; step(); clearFinish();

    // R5 set wins over simultaneous clear
    progCount = 4'd1; chanEn = 1; step();
    beatDone = 1; finishClr = 1; step(); beatDone = 0; finishClr = 0;
    check("R5 set beats clear", int'(finishFlag), 1);
    chanEn = 0; step(); clearFinish();

    // R9 transfer error
    progCount = 4'd5; chanEn = 1; step();
    beatDone = 1; step(); step(); beatDone = 0;
    xferErr = 1; step(); xferErr = 0;
    check("R9 err inactive", int'(chanActive), 0);
    check("R9 err flag", int'(errFlag), 1);
    check("R9 err holds count", int'(curCount), 3);
    step();
    check("R9 err sticky", int'(errFlag), 1);
    errClr = 1; step(); errClr = 0;
    check("R9 err cleared", int'(errFlag), 0);

    // R13 held enable does not restart after a stop
    check("R13 no restart after error", int'(chanActive), 0);
    chanEn = 0; step();

    // R12 strobes ignored while inactive
    beatDone = 1; xferErr = 1; step(); step();
    beatDone = 0; xferErr = 0;
    check("R12 count unchanged", int'(curCount), 3);
    check("R12 stays inactive", int'(chanActive), 0);
    check("R12 no error flag", int'(errFlag), 0);

    // R11 zero count refused, R13 new edge needed
    progCount = '0; chanEn = 1; step();
    check("R11 zero no start", int'(chanActive), 0);
    progCount = 4'd4; step();
    check("R13 held enable no start", int'(chanActive), 0);
    chanEn = 0; step(); chanEn = 1; step();
    check("R13 new edge starts", int'(chanActive), 1);
    check("R13 new edge count", int'(curCount), 4);
    chanEn = 0; step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule